// File: doc/BRIEF.md
# Serially Configured Memory Bank Manager

This block sits beside an 8-bit CPU and turns the top four address bits, the read/write line and the PHI2 phase into chip selects for RAM, ROM, a peripheral interface chip and a floppy controller. It also produces the shared memory output and write enables. It drives four upper address lines to the memory devices, `bank_addr[3:0]`, with bit 3 the highest. These lines choose which part of a 32 KB RAM, and which part of a ROM of up to 128 KB, the CPU sees.

The bank choices, the floppy controller clock rate and the drive unit select live in a small configuration register. The CPU loads it one bit per write cycle through data bit D7, using a dedicated 4 KB window. The shift register fills from its least significant bit. The active register is updated only on every eighth counted write. Until a full byte has arrived, the map uses its power-on defaults. Under those defaults the ROM top bank sits at $8000, the bottom RAM bank sits at $0000, the slow clock is selected and the primary drive is selected.

Top module: `mem_bank_mgr`

## Requirements
- R1: After reset, `fdc_clk_fast` is 0 (8 MHz) and `drive_primary_n` is 0. The ROM bank is 3, so `bank_addr[3:2]`=11 in the $8000 window. The RAM bank is 0.
- R2: For A15..A12 in 0..3, `ram_cs_n` is 0. In that window `bank_addr` = {1, 1, RAM bank bit, A13}.
- R3: `pia_cs_n` is 0 exactly for A15..A12 = 4. `fdc_cs_n` is 0 exactly for A15..A12 = 6 while PHI2 is high.
- R4: For A15 = 1, `rom_cs_n` is 0 and `bank_addr` = {ROM bank[1:0], A14, A13}.
- R5: For A15..A12 = 5, `rom_cs_n` is 0 and `bank_addr` is 0000, whatever the configuration.
- R6: `mem_we_n` is 0 only while R/W is 0 and PHI2 is 1. `mem_oe_n` is 0 exactly while R/W is 1.
- R7: A counted write happens when PHI2 falls, sampled on `clk`, while A15..A12 = 7 and R/W = 0; it shifts D7 into an 8-bit register, first bit into bit 0. On the eighth counted write, the byte becomes active. Its fields are: bits[1:0] ROM bank, bit 2 RAM bank, bit 3 fast clock (1 = 16 MHz), bit 4 secondary drive (1 drives `drive_primary_n` high). Bits 7..5 are ignored.
- R8: Reads in the window and writes elsewhere are not counted. Fewer than eight counted writes leave the active configuration unchanged. Reset clears the bit count.
- R9: For A15..A12 = 7, no chip select is active and `bank_addr` is 1111.
- R10: After each transfer, the bit count restarts, so the next eight counted writes form a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than PHI2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr_hi | input | 4 | CPU address bits A15..A12 (bit 3 = A15) |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_phi2 | input | 1 | CPU PHI2 phase |
| cpu_d7 | input | 1 | CPU data bit 7, serial configuration input |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| pia_cs_n | output | 1 | Peripheral interface chip select, active low |
| fdc_cs_n | output | 1 | Floppy controller select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| bank_addr | output | 4 | Upper memory address lines (bit 3 highest) |
| fdc_clk_fast | output | 1 | 1 selects 16 MHz floppy clock, 0 selects 8 MHz |
| drive_primary_n | output | 1 | Low selects primary drive, high selects secondary |

## Verification
The assertions assume that `clk` is fast enough to see every PHI2 phase in at least one sample. They also assume that the address, R/W and D7 stay put from the sample before PHI2 falls until the sample at which the fall is seen. The bench follows this rule. Each configuration write is a negedge-aligned sequence: address and data are set with PHI2 high, then PHI2 is dropped while the address is held, and only afterwards does the address move. The combinational decode vectors never present a falling PHI2 with a window address and R/W low. Because of this, no write is counted by accident.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  localparam int NIB_W   = 4;
  localparam int SHIFT_W = 8;
  localparam int CNT_W   = $clog2(SHIFT_W);
  localparam logic [NIB_W-1:0] CFG_NIB = 4'd7;
  localparam logic [NIB_W-1:0] FIX_NIB = 4'd5;
  localparam logic [NIB_W-1:0] PIA_NIB = 4'd4;
  localparam logic [NIB_W-1:0] FDC_NIB = 4'd6;

  typedef enum logic [2:0] {
    REG_RAM,
    REG_PIA,
    REG_FIXROM,
    REG_FDC,
    REG_CFG,
    REG_ROM
  } region_e;

  typedef struct packed {
    logic       sec_drive;
    logic       fdc_fast;
    logic       ram_bank;
    logic [1:0] rom_bank;
  } cfg_t;

  localparam int CFG_USED = $bits(cfg_t);

  localparam cfg_t CFG_RESET = '{sec_drive: 1'b0, fdc_fast: 1'b0,
                                 ram_bank: 1'b0, rom_bank: 2'b11};

  function automatic region_e region_of(input logic [NIB_W-1:0] nib);
    region_e r;
    if (nib[3])                    r = REG_ROM;
    else if (nib[2] == 1'b0)       r = REG_RAM;
    else if (nib == PIA_NIB)       r = REG_PIA;
    else if (nib == FIX_NIB)       r = REG_FIXROM;
    else if (nib == FDC_NIB)       r = REG_FDC;
    else                           r = REG_CFG;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

endpackage

// File: rtl/addr_decoder.sv
module addr_decoder
  import mbm_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic             rw,
  input  logic             phi2,
  output region_e          region,
  output logic             rom_cs_n,
  output logic             ram_cs_n,
  output logic             pia_cs_n,
  output logic             fdc_cs_n,
  output logic             oe_n,
  output logic             we_n
);

  always_comb begin
    region   = region_of(nib);
    rom_cs_n = !((region == REG_ROM) || (region == REG_FIXROM));
    ram_cs_n = !(region == REG_RAM);
    pia_cs_n = !(region == REG_PIA);
    fdc_cs_n = !((region == REG_FDC) && phi2);
    oe_n     = !rw;
    we_n     = !(!rw && phi2);
  end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import mbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] nib,
  input  logic             rw,
  input  logic             phi2,
  input  logic             d7,
  output cfg_t             cfg_q,
  output logic             wr_ev,
  output logic             xfer_ev
);

  logic               phi2_q;
  logic [NIB_W-1:0]   nib_q;
  logic               rw_q;
  logic               d7_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [SHIFT_W-1:0] shift_d;
  logic [CNT_W-1:0]   bit_cnt;

  // Bus phase sampling; a write is seen on the PHI2 falling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi2_q <= 1'b0;
      nib_q  <= '0;
      rw_q   <= 1'b1;
      d7_q   <= 1'b0;
    end else begin
      phi2_q <= phi2;
      nib_q  <= nib;
      rw_q   <= rw;
      d7_q   <= d7;
    end
  end

  assign wr_ev   = phi2_q && !phi2 && (nib_q == CFG_NIB) && !rw_q;
  assign xfer_ev = wr_ev && (bit_cnt == CNT_W'(SHIFT_W - 1));
  assign shift_d = {d7_q, shift_q[SHIFT_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bit_cnt <= '0;
      cfg_q   <= CFG_RESET;
    end else if (wr_ev) begin
      shift_q <= shift_d;
      bit_cnt <= count_next(bit_cnt);
      if (xfer_ev) cfg_q <= cfg_t'(shift_d[CFG_USED-1:0]);
    end
  end

  a_r8_hold_without_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ev |=> $stable(cfg_q));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !xfer_ev) |=> (bit_cnt == CNT_W'($past(bit_cnt) + 1)));

  a_r10_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ev |=> (bit_cnt == '0));

  a_r8_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(bit_cnt));

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mbm_pkg::*;
#(
  parameter int ROM_KB = 128
) (
  input  region_e    region,
  input  logic [1:0] a14_a13,
  input  logic [1:0] rom_bank,
  input  logic       ram_bank,
  output logic [3:0] bank_addr
);

  localparam int ROM_BANKS     = ROM_KB / 32;
  localparam int ROM_BANK_BITS = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 0;

  logic [1:0] rom_hi;

  generate
    if (ROM_BANK_BITS == 0) begin : g_rom32
      assign rom_hi = 2'b11;
    end else if (ROM_BANK_BITS == 1) begin : g_rom64
      assign rom_hi = {1'b1, rom_bank[0]};
    end else begin : g_rom128
      assign rom_hi = rom_bank;
    end
  endgenerate

  always_comb begin
    case (region)
      REG_FIXROM: bank_addr = 4'b0000;
      REG_RAM:    bank_addr = {2'b11, ram_bank, a14_a13[0]};
      REG_ROM:    bank_addr = {rom_hi, a14_a13};
      default:    bank_addr = {2'b11, a14_a13};
    endcase
  end

endmodule

// File: rtl/mem_bank_mgr.sv
module mem_bank_mgr
  import mbm_pkg::*;
#(
  parameter int ROM_KB = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cpu_addr_hi,
  input  logic       cpu_rw,
  input  logic       cpu_phi2,
  input  logic       cpu_d7,
  output logic       rom_cs_n,
  output logic       ram_cs_n,
  output logic       pia_cs_n,
  output logic       fdc_cs_n,
  output logic       mem_oe_n,
  output logic       mem_we_n,
  output logic [3:0] bank_addr,
  output logic       fdc_clk_fast,
  output logic       drive_primary_n
);

  region_e region;
  cfg_t    cfg_q;
  logic    wr_ev;
  logic    xfer_ev;

  addr_decoder u_dec (
    .nib      (cpu_addr_hi),
    .rw       (cpu_rw),
    .phi2     (cpu_phi2),
    .region   (region),
    .rom_cs_n (rom_cs_n),
    .ram_cs_n (ram_cs_n),
    .pia_cs_n (pia_cs_n),
    .fdc_cs_n (fdc_cs_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n)
  );

  cfg_loader u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .nib     (cpu_addr_hi),
    .rw      (cpu_rw),
    .phi2    (cpu_phi2),
    .d7      (cpu_d7),
    .cfg_q   (cfg_q),
    .wr_ev   (wr_ev),
    .xfer_ev (xfer_ev)
  );

  bank_mapper #(.ROM_KB(ROM_KB)) u_map (
    .region    (region),
    .a14_a13   (cpu_addr_hi[2:1]),
    .rom_bank  (cfg_q.rom_bank),
    .ram_bank  (cfg_q.ram_bank),
    .bank_addr (bank_addr)
  );

  assign fdc_clk_fast    = cfg_q.fdc_fast;
  assign drive_primary_n = cfg_q.sec_drive;

  a_r3_fdc_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !fdc_cs_n |-> cpu_phi2 && (cpu_addr_hi == 4'd6));

  a_r9_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!rom_cs_n, !ram_cs_n, !pia_cs_n, !fdc_cs_n}));

  a_r5_fixed_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr_hi == 4'd5) |-> (bank_addr == 4'b0000) && !rom_cs_n);

  a_r6_write_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !cpu_rw && cpu_phi2 && mem_oe_n);

  a_r4_rom_low_lines: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr_hi[3] |-> (bank_addr[1:0] == cpu_addr_hi[2:1]) && !rom_cs_n);

endmodule

// File: tb/tb_mem_bank_mgr.sv
module tb_mem_bank_mgr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] nib = 4'd0;
  logic       rw = 1'b1;
  logic       phi2 = 1'b0;
  logic       d7 = 1'b0;
  logic       rom_cs_n, ram_cs_n, pia_cs_n, fdc_cs_n, oe_n, we_n;
  logic [3:0] bank_addr;
  logic       fdc_fast, prim_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_bank_mgr dut (
    .clk (clk), .rst_n (rst_n), .cpu_addr_hi (nib), .cpu_rw (rw),
    .cpu_phi2 (phi2), .cpu_d7 (d7), .rom_cs_n (rom_cs_n), .ram_cs_n (ram_cs_n),
    .pia_cs_n (pia_cs_n), .fdc_cs_n (fdc_cs_n), .mem_oe_n (oe_n),
    .mem_we_n (we_n), .bank_addr (bank_addr), .fdc_clk_fast (fdc_fast),
    .drive_primary_n (prim_n)
  );

  // stimulus {nib, rw, phi2}; expected {rom,ram,pia,fdc,oe,we,bank_addr}
  localparam int NV = 12;
  localparam logic [5:0] STIM [NV] = '{
    {4'h0, 1'b1, 1'b1}, {4'h3, 1'b0, 1'b1}, {4'h4, 1'b1, 1'b0},
    {4'h6, 1'b1, 1'b1}, {4'h6, 1'b1, 1'b0}, {4'h5, 1'b1, 1'b1},
    {4'h7, 1'b1, 1'b1}, {4'h8, 1'b1, 1'b1}, {4'hA, 1'b0, 1'b1},
    {4'hF, 1'b0, 1'b0}, {4'h1, 1'b0, 1'b0}, {4'hC, 1'b1, 1'b0}
  };
  localparam logic [9:0] EXPV [NV] = '{
    10'b1011_01_1100, 10'b1011_10_1101, 10'b1101_01_1110,
    10'b1110_01_1111, 10'b1111_01_1111, 10'b0111_01_0000,
    10'b1111_01_1111, 10'b0111_01_1100, 10'b0111_10_1101,
    10'b0111_11_1111, 10'b1011_11_1100, 10'b0111_01_1110
  };
  localparam string TAGV [NV] = '{
    "R2", "R2", "R3", "R3", "R3", "R5", "R9", "R4", "R4", "R6", "R6", "R4"
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic b);
    @(negedge clk); nib = 4'h7; rw = 1'b0; phi2 = 1'b1; d7 = b;
    @(negedge clk); phi2 = 1'b0;
    @(negedge clk); rw = 1'b1; nib = 4'h0; d7 = 1'b0;
  endtask

  task automatic load_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) cfg_write(v[i]);
  endtask

  task automatic peek(input logic [3:0] n, input string tag, input logic [3:0] exp_ba);
    @(negedge clk); nib = n; rw = 1'b1; phi2 = 1'b0;
    #1 chk(tag, {12'd0, bank_addr}, {12'd0, exp_ba});
  endtask

  task automatic cfg_out(input string tag, input logic f, input logic p);
    #1 chk(tag, {14'd0, fdc_fast, prim_n}, {14'd0, f, p});
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset defaults
    cfg_out("R1 reset cfg", 1'b0, 1'b0);
    peek(4'h8, "R1 reset rom bank", 4'b1100);
    peek(4'h2, "R1 reset ram bank", 4'b1101);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {nib, rw, phi2} = STIM[k];
      #1 chk(TAGV[k], {6'd0, rom_cs_n, ram_cs_n, pia_cs_n, fdc_cs_n, oe_n, we_n, bank_addr},
             {6'd0, EXPV[k]});
    end
    @(negedge clk); phi2 = 1'b0; rw = 1'b1; nib = 4'h0;

    // R8 partial sequence plus uncounted cycles
    for (int i = 0; i < 5; i++) cfg_write(1'b1);
    cfg_out("R8 five writes", 1'b0, 1'b0);
    @(negedge clk); nib = 4'h7; rw = 1'b1; phi2 = 1'b1;   // read in window
    @(negedge clk); phi2 = 1'b0;
    @(negedge clk); nib = 4'h0; rw = 1'b0; phi2 = 1'b1;   // write elsewhere
    @(negedge clk); phi2 = 1'b0;
    @(negedge clk); rw = 1'b1;
    cfg_write(1'b1); cfg_write(1'b1);
    cfg_out("R8 seven counted", 1'b0, 1'b0);
    cfg_write(1'b1);
    cfg_out("R7 eighth write", 1'b1, 1'b1);
    peek(4'h8, "R7 all ones rom", 4'b1100);
    peek(4'h0, "R2 ram bank 1", 4'b1110);

    // R10 fresh byte after transfer: 0x06 -> rom 2, ram 1, slow, primary
    load_byte(8'h06);
    cfg_out("R10 second byte", 1'b0, 1'b0);
    peek(4'h8, "R4 rom bank 2", 4'b1000);
    peek(4'h3, "R2 ram bank 1 a13", 4'b1111);
    peek(4'h5, "R5 fixed after bank", 4'b0000);
    peek(4'h7, "R9 cfg window lines", 4'b1111);

    // R7 LSB-first ordering: 0x19 -> rom 1, ram 0, fast, secondary
    load_byte(8'h19);
    cfg_out("R7 lsb first cfg", 1'b1, 1'b1);
    peek(4'hC, "R7 lsb first rom", 4'b0110);
    peek(4'h1, "R2 ram bank 0", 4'b1100);

    // R8 reset mid-sequence clears count and config
    for (int i = 0; i < 4; i++) cfg_write(1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_out("R1 after reset", 1'b0, 1'b0);
    peek(4'h8, "R1 after reset rom", 4'b1100);
    for (int i = 0; i < 7; i++) cfg_write(i == 3);
    cfg_out("R8 count cleared by reset", 1'b0, 1'b0);
    cfg_write(1'b0);
    cfg_out("R7 fast only", 1'b1, 1'b0);
    peek(4'h9, "R4 rom bank 0", 4'b0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule